// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is a serial shift register that software reads and writes directly. No holding buffer sits between the register port and the shifting bits. Each shift moves the contents one place toward the most significant bit, and the serial input enters at bit 0. A two-bit select chooses what advances the register: a software strobe, a timer compare-match pulse, or a rising or falling edge of an external serial clock. The external serial clock and serial data input pass through a multi-stage synchroniser into the system clock domain, and edges are detected on the synchronised clock. No mode or enable has to be set before the external pins can move the register.

The serial data output carries the most significant bit through a latch. With an internal source (strobe or timer), the latch is always transparent. With an external source, it is transparent only in the half of the serial clock period before the active edge. It closes on the active edge and reopens on the opposite edge. As a result, the input is sampled on one edge of the serial clock and the output changes on the other.

The register port is a plain control port rather than a stream. A write is always accepted in the cycle it is presented and there is no back-pressure. Read data is the live register contents. If a write and a shift event fall in the same cycle, the write wins and the shift is dropped.

Top module: `serial_shift_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the register reads 0x00 and the serial output is 0.
- R2: A register write presented on one clock edge is visible on the read data immediately after that edge.
- R3: With select 2'b00, each cycle with the software strobe high shifts the register left by one. The new bit 0 is the synchronised serial input.
- R4: With select 2'b01, each cycle with the compare-match input high shifts the register left by one in the same way.
- R5: With select 2'b10, a rising edge of the synchronised serial clock shifts the register. A rise of the serial clock first sampled at edge k shows on the read data after edge k+SYNC_STAGES.
- R6: With select 2'b11, a falling edge of the synchronised serial clock shifts the register, with the same latency as R5.
- R7: When a write and a shift event occur in the same cycle, the register takes the written value and no shift occurs.
- R8: With an internal source (select bit 1 = 0), the serial output always equals bit 7 of the register. A write changes it straight after the write edge.
- R9: With an external source, the output latch is transparent while the synchronised serial clock is at the level opposite to the active edge. It holds otherwise, so a shift leaves the old most significant bit on the output until the opposite edge.
- R10: With an external source and the latch closed, a register write does not change the serial output until the latch reopens.
- R11: Sources not picked by the select have no effect: the strobe and compare-match inputs are ignored in the external modes, and each internal mode ignores the other internal input and all serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | WIDTH | Value to write |
| reg_rd_data | output | WIDTH | Live register contents |
| clk_sel | input | 2 | Shift source: 00 strobe, 01 timer match, 10 external rising, 11 external falling |
| sw_strobe | input | 1 | Software shift strobe, one shift per high cycle |
| tmr_match | input | 1 | Timer compare-match pulse |
| sdi | input | 1 | Serial data in, asynchronous |
| sck | input | 1 | External serial clock, asynchronous |
| sdo | output | 1 | Serial data out from the latched most significant bit |

## Verification
The bench builds the block with WIDTH 8 and SYNC_STAGES 2. This makes a full byte walk out in eight shifts, and puts the two-edge synchroniser latency where a directed check can pin the exact cycle of an external shift. A serial clock with a period of several system cycles in both edge polarities lets the latch be observed closed and open. A write landing on either side of that boundary shows whether the output follows or holds.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    SRC_STROBE   = 2'b00,
    SRC_TIMER    = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } shift_src_e;

  function automatic logic src_is_external(shift_src_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/ssr_tick_sel.sv
module ssr_tick_sel
  import ssr_pkg::*;
(
  input  shift_src_e sel,
  input  logic       strobe,
  input  logic       match,
  input  logic       ext_rise,
  input  logic       ext_fall,
  input  logic       ext_lvl,
  output logic       tick,
  output logic       latch_open
);
  always_comb begin
    tick       = 1'b0;
    latch_open = 1'b1;
    case (sel)
      SRC_STROBE:   tick = strobe;
      SRC_TIMER:    tick = match;
      SRC_EXT_RISE: begin
        tick       = ext_rise;
        latch_open = ~ext_lvl;
      end
      SRC_EXT_FALL: begin
        tick       = ext_fall;
        latch_open = ext_lvl;
      end
      default: begin
        tick       = 1'b0;
        latch_open = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ssr_core.sv
module ssr_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             tick,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en)     nxt = wr_data;
    else if (tick) nxt = {q[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/ssr_latch.sv
module ssr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic open,
  input  logic msb,
  output logic sdo
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= 1'b0;
    else if (open) held <= msb;
  end

  assign sdo = open ? msb : held;
endmodule

// File: rtl/serial_shift_reg.sv
module serial_shift_reg
  import ssr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [WIDTH-1:0] reg_wr_data,
  output logic [WIDTH-1:0] reg_rd_data,
  input  logic [1:0]       clk_sel,
  input  logic             sw_strobe,
  input  logic             tmr_match,
  input  logic             sdi,
  input  logic             sck,
  output logic             sdo
);
  localparam int PINS = 2;

  logic [PINS-1:0] pins_sync;
  logic            sck_s, sdi_s, rise, fall, tick, latch_open;
  logic [WIDTH-1:0] sr_q;

  ssr_sync #(.STAGES(SYNC_STAGES), .WIDTH(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, sdi}), .q(pins_sync)
  );
  assign sck_s = pins_sync[1];
  assign sdi_s = pins_sync[0];

  ssr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(rise), .fall(fall)
  );

  ssr_tick_sel u_tsel (
    .sel(shift_src_e'(clk_sel)), .strobe(sw_strobe), .match(tmr_match),
    .ext_rise(rise), .ext_fall(fall), .ext_lvl(sck_s),
    .tick(tick), .latch_open(latch_open)
  );

  ssr_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .tick(tick), .ser_in(sdi_s), .q(sr_q)
  );

  ssr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .open(latch_open), .msb(sr_q[WIDTH-1]), .sdo(sdo)
  );

  assign reg_rd_data = sr_q;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [WIDTH-1:0] reg_wr_data,
  input logic [WIDTH-1:0] reg_rd_data,
  input logic [1:0]       clk_sel,
  input logic             sw_strobe,
  input logic             tmr_match,
  input logic             sdo
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_rd_data == '0 && sdo == 1'b0));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data));

  assert_strobe_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00 && sw_strobe && !reg_wr_en)
      |=> reg_rd_data[WIDTH-1:1] == $past(reg_rd_data[WIDTH-2:0]));

  assert_match_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b01 && tmr_match && !reg_wr_en)
      |=> reg_rd_data[WIDTH-1:1] == $past(reg_rd_data[WIDTH-2:0]));

  assert_internal_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[1] == 1'b0) |-> sdo == reg_rd_data[WIDTH-1]);

  assert_idle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00 && !sw_strobe && !reg_wr_en) |=> $stable(reg_rd_data));

  assert_idle_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b01 && !tmr_match && !reg_wr_en) |=> $stable(reg_rd_data));
endmodule

bind serial_shift_reg ssr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data), .clk_sel(clk_sel), .sw_strobe(sw_strobe),
  .tmr_match(tmr_match), .sdo(sdo)
);

// File: tb/serial_shift_reg_bench.sv
module serial_shift_reg_bench;
  localparam int W = 8;
  localparam int N = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [W-1:0] reg_wr_data = '0;
  logic [W-1:0] reg_rd_data;
  logic [1:0]   clk_sel = 2'b00;
  logic         sw_strobe = 1'b0, tmr_match = 1'b0, sdi = 1'b0, sck = 1'b0;
  logic         sdo;

  serial_shift_reg #(.WIDTH(W), .SYNC_STAGES(N)) u_serial_shift_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .clk_sel(clk_sel), .sw_strobe(sw_strobe),
    .tmr_match(tmr_match), .sdi(sdi), .sck(sck), .sdo(sdo)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  // behavioural reference
  logic [W-1:0] m_sr = '0;
  logic         m_held = 1'b0, m_prev = 1'b0;
  logic         m_sckq[$], m_sdiq[$];

  function automatic logic m_open();
    logic lv = m_sckq[N-1];
    if (clk_sel == 2'b10) return !lv;
    if (clk_sel == 2'b11) return lv;
    return 1'b1;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_sckq.push_back(1'b0);
      m_sdiq.push_back(1'b0);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = '0; m_held = 1'b0; m_prev = 1'b0;
      for (int i = 0; i < N; i++) begin
        m_sckq[i] = 1'b0;
        m_sdiq[i] = 1'b0;
      end
    end else begin
      logic lv, din, shift_ev;
      lv  = m_sckq[N-1];
      din = m_sdiq[N-1];
      case (clk_sel)
        2'b00: shift_ev = sw_strobe;
        2'b01: shift_ev = tmr_match;
        2'b10: shift_ev = lv && !m_prev;
        default: shift_ev = !lv && m_prev;
      endcase
      if (m_open()) m_held = m_sr[W-1];
      if (reg_wr_en)     m_sr = reg_wr_data;
      else if (shift_ev) m_sr = {m_sr[W-2:0], din};
      m_prev = lv;
      void'(m_sckq.pop_back());
      void'(m_sdiq.pop_back());
      m_sckq.push_front(sck);
      m_sdiq.push_front(sdi);
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, "model rd_data", 32'(reg_rd_data), 32'(m_sr));
      chk(cur_req, "model sdo", 32'(sdo), 32'(m_open() ? m_sr[W-1] : m_held));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic wr(logic [W-1:0] v);
    reg_wr_en = 1'b1; reg_wr_data = v; step(); reg_wr_en = 1'b0;
  endtask

  task automatic noise_ext(int half, int periods);
    for (int p = 0; p < 2 * periods; p++) begin
      sck = ~sck;
      for (int h = 0; h < half; h++) begin
        sdi = 1'($urandom);
        sw_strobe = 1'($urandom);
        tmr_match = 1'($urandom);
        step();
      end
    end
    sw_strobe = 1'b0; tmr_match = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) step();
    at_neg();
    chk("R1", "rd in reset", 32'(reg_rd_data), 32'h0);
    chk("R1", "sdo in reset", 32'(sdo), 32'h0);
    step(); rst_n = 1'b1; step();
    at_neg();
    chk("R1", "rd after reset", 32'(reg_rd_data), 32'h0);
    cmp_on = 1'b1;

    // R2 direct write / read, R8 sdo follows
    cur_req = "R2";
    wr(8'hA5); at_neg();
    chk("R2", "rd after write", 32'(reg_rd_data), 32'hA5);
    chk("R8", "sdo follows msb", 32'(sdo), 32'h1);
    step(); wr(8'h35); at_neg();
    chk("R8", "sdo follows new msb", 32'(sdo), 32'h0);

    // R3 strobe shifts
    cur_req = "R3";
    step(); wr(8'h81); sdi = 1'b1; repeat (3) step();
    sw_strobe = 1'b1; step(); sw_strobe = 1'b0; at_neg();
    chk("R3", "strobe shift", 32'(reg_rd_data), 32'h03);
    for (int i = 0; i < 20; i++) begin
      sdi = 1'($urandom); sw_strobe = 1'($urandom); step();
    end
    sw_strobe = 1'b0;

    // R11 timer ignored in strobe mode
    cur_req = "R11";
    step(); wr(8'h5C); tmr_match = 1'b1; sck = 1'b1; repeat (6) step();
    sck = 1'b0; repeat (4) step(); tmr_match = 1'b0; at_neg();
    chk("R11", "match/sck ignored in strobe mode", 32'(reg_rd_data), 32'h5C);

    // R4 timer match shifts, strobe ignored
    cur_req = "R4";
    clk_sel = 2'b01; step(); wr(8'h40); sdi = 1'b0; repeat (3) step();
    tmr_match = 1'b1; step(); tmr_match = 1'b0; at_neg();
    chk("R4", "match shift", 32'(reg_rd_data), 32'h80);
    sw_strobe = 1'b1; repeat (3) step(); sw_strobe = 1'b0; at_neg();
    chk("R11", "strobe ignored in timer mode", 32'(reg_rd_data), 32'h80);
    for (int i = 0; i < 20; i++) begin
      sdi = 1'($urandom); tmr_match = 1'($urandom); step();
    end
    tmr_match = 1'b0;

    // R7 collision
    cur_req = "R7";
    step(); tmr_match = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 8'hC3; step();
    reg_wr_en = 1'b0; tmr_match = 1'b0; at_neg();
    chk("R7", "write beats shift", 32'(reg_rd_data), 32'hC3);

    // R5 external rising, exact latency
    cur_req = "R5";
    clk_sel = 2'b10; sck = 1'b0; sdi = 1'b1; step(); wr(8'h81); repeat (4) step();
    sck = 1'b1;
    step(); at_neg();
    chk("R5", "no shift after 1 edge", 32'(reg_rd_data), 32'h81);
    step(); at_neg();
    chk("R5", "no shift after 2 edges", 32'(reg_rd_data), 32'h81);
    chk("R9", "latch holds old msb", 32'(sdo), 32'h1);
    step(); at_neg();
    chk("R5", "shift after 3 edges", 32'(reg_rd_data), 32'h03);
    chk("R9", "output holds after shift", 32'(sdo), 32'h1);
    sck = 1'b0; repeat (4) step(); at_neg();
    chk("R9", "latch reopens on falling", 32'(sdo), 32'h0);

    // R10 write while closed
    cur_req = "R10";
    wr(8'h80); step(); at_neg();
    chk("R9", "open latch shows write", 32'(sdo), 32'h1);
    sck = 1'b1; repeat (4) step();
    wr(8'h00); at_neg();
    chk("R10", "closed latch holds", 32'(sdo), 32'h1);
    chk("R10", "register took write", 32'(reg_rd_data), 32'h00);
    sck = 1'b0; repeat (4) step(); at_neg();
    chk("R10", "reopened shows write", 32'(sdo), 32'h0);

    cur_req = "R5";
    noise_ext(4, 12);

    // R6 external falling
    cur_req = "R6";
    clk_sel = 2'b11; sck = 1'b1; repeat (4) step(); wr(8'h11); sdi = 1'b0; repeat (3) step();
    sck = 1'b0; repeat (2) step(); at_neg();
    chk("R6", "no shift yet", 32'(reg_rd_data), 32'h11);
    step(); at_neg();
    chk("R6", "falling shift", 32'(reg_rd_data), 32'h22);
    noise_ext(3, 12);

    cur_req = "R8";
    clk_sel = 2'b00;
    for (int i = 0; i < 16; i++) begin
      sw_strobe = 1'($urandom); sdi = 1'($urandom);
      reg_wr_en = (i % 5 == 0); reg_wr_data = 8'($urandom); step();
    end
    reg_wr_en = 1'b0; sw_strobe = 1'b0;
    step(); at_neg();

    cmp_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule